// File: doc/BRIEF.md
# Slotted Bucket Hash Unit

This block keeps one hash table in an external memory whose word is 256 bits wide. Each memory word is one bucket of four 64-bit slots, and each slot holds a 32-bit key and a 32-bit value. A requester sends inserts (key and value) and probes (key) over a valid/ready handshake. For every request the unit takes the key modulo the bucket count, forms a word address and issues one bucket read. When the read data comes back, a probe looks for a slot with a matching key. An insert fills the first empty slot and writes the whole bucket back to the same address.

Collisions are settled only by the four slots of a bucket, with no chaining. A full bucket makes the insert fail with an overflow status, which tells the join that it has run out of memory. The unit is pipelined. It keeps many reads in flight, relies on memory returning read data in issue order, and answers every request in the order it was accepted. The table's base address and its stride between buckets are parameters, so several tables can interleave their buckets in one memory. Two requests in flight to the same bucket are not reconciled, so the requester must keep them apart.

Top module: `hash_bucket_unit`

## Requirements
- R1: During and right after a synchronous active-low reset, `rsp_valid` and `mem_wr_valid` are low, and `mem_rd_valid` is low while `req_valid` is low. Once reset is released with memory ready, `req_ready` is high.
- R2: For a request with key k, the bucket read and any write-back go to address TABLE_BASE + (k mod NUM_BUCKETS) × TABLE_STRIDE.
- R3: Slot j occupies bucket bits [64j+63:64j], with the key in the upper 32 bits. A key of 0xFFFFFFFF marks an empty slot. A successful insert stores its pair in the lowest-numbered empty slot, leaves the other slots unchanged, writes the bucket back exactly once, and answers status 0 with value 0.
- R4: A probe whose key matches a slot answers status 0 with the value of the lowest-numbered matching slot. A probe never writes memory.
- R5: A probe with no matching slot answers status 1 (miss) with value 0.
- R6: An insert into a bucket with no empty slot answers status 2 (overflow) with value 0, issues no write, and leaves the pair unstored, so a later probe of that key misses.
- R7: A request whose key is 0xFFFFFFFF answers status 3 (reserved key) with value 0 and issues no write.
- R8: Responses leave in the order the requests were accepted. Each carries the request's tag and its opcode (`rsp_is_insert` is 1 for an insert and 0 for a probe).
- R9: No more than MAX_OUTST reads await data at any time. While the response port is stalled, the unit accepts exactly MAX_OUTST+1 requests and then holds `req_ready` low.
- R10: While the response port or the write port is stalled, that port keeps its valid signal high and its contents unchanged until the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_is_insert | input | 1 | 1 = insert, 0 = probe |
| req_key | input | 32 | Key of the request |
| req_value | input | 32 | Value to store (inserts only) |
| req_tag | input | TAG_W | Requester tag echoed in the response |
| mem_rd_valid | output | 1 | Bucket read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Word address of the bucket read |
| mem_rsp_valid | input | 1 | Read data present (in issue order) |
| mem_rsp_ready | output | 1 | Unit consumes the read data |
| mem_rsp_data | input | 256 | Bucket contents |
| mem_wr_valid | output | 1 | Bucket write-back request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Word address of the write-back |
| mem_wr_data | output | 256 | Updated bucket |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_is_insert | output | 1 | Opcode of the answered request |
| rsp_status | output | 2 | 0 ok, 1 miss, 2 overflow, 3 reserved key |
| rsp_value | output | 32 | Probe value on a hit, otherwise 0 |

## Verification
The bench builds the unit with eight buckets, a base of 16 and a stride of 3. Keys that differ by eight then land in the same bucket at a spaced, offset address, and five such inserts fill a bucket and reach the overflow case. The address formula and the slot layout are checked against the memory model's contents. The in-flight limit keeps its default of 32, so stalling the response port and counting accepted requests reaches the full-queue case in a few dozen cycles. The same burst also checks response order.

// File: rtl/hbu_pkg.sv
// Shared constants and types for the slotted bucket hash unit.
// Assumes a bucket is one 256-bit memory word holding four 64-bit slots.
package hbu_pkg;

    localparam int KEY_W    = 32;
    localparam int VAL_W    = 32;
    localparam int SLOT_W   = KEY_W + VAL_W;
    localparam int SLOTS    = 4;
    localparam int BUCKET_W = SLOT_W * SLOTS;
    localparam int SLOT_IX_W = $clog2(SLOTS);

    localparam logic [KEY_W-1:0] EMPTY_KEY = '1;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_MISS = 2'd1,
        ST_OVF  = 2'd2,
        ST_RSVD = 2'd3
    } hbu_status_e;

endpackage

// File: rtl/hbu_meta_fifo.sv
// In-order metadata queue: holds one entry per read in flight so that each
// in-order memory response can be paired with the request that caused it.
// Assumes pop is only asserted when not empty and push only when not full.
module hbu_meta_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Storage array write port, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head of queue and status flags.
    always_comb begin
        dout  = store[rd_ptr];
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/hbu_bucket_locator.sv
// Maps a key to the word address of its bucket:
// base + (key mod buckets) * stride. Purely combinational.
// Assumes keys are dense integers so the modulo spreads them evenly.
module hbu_bucket_locator
    import hbu_pkg::*;
#(
    parameter int          NUM_BUCKETS  = 64,
    parameter int          ADDR_W       = 32,
    parameter int unsigned TABLE_BASE   = 0,
    parameter int unsigned TABLE_STRIDE = 1
) (
    input  logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [KEY_W-1:0]  NB_K   = KEY_W'(NUM_BUCKETS);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
    localparam logic [ADDR_W-1:0] STR_A  = ADDR_W'(TABLE_STRIDE);

    logic [KEY_W-1:0] bucket_idx;

    // Bucket index and its scaled, offset word address.
    always_comb begin
        bucket_idx = key % NB_K;
        addr       = BASE_A + ADDR_W'(bucket_idx) * STR_A;
    end

endmodule

// File: rtl/hbu_slot_logic.sv
// Examines one bucket against a key: finds the lowest matching slot, the
// lowest empty slot, and builds the bucket with the new pair placed in
// that empty slot. Combinational only; the caller decides what to use.
module hbu_slot_logic
    import hbu_pkg::*;
(
    input  logic [BUCKET_W-1:0] bucket,
    input  logic [KEY_W-1:0]    key,
    input  logic [VAL_W-1:0]    value,
    output logic                hit,
    output logic [VAL_W-1:0]    hit_value,
    output logic                has_free,
    output logic [BUCKET_W-1:0] new_bucket
);

    logic [SLOTS-1:0]     match_vec;
    logic [SLOTS-1:0]     empty_vec;
    logic [SLOT_IX_W-1:0] free_ix;
    logic [SLOT_IX_W-1:0] hit_ix;

    // Per-slot key comparators.
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        assign match_vec[j] = (bucket[j*SLOT_W + VAL_W +: KEY_W] == key);
        assign empty_vec[j] = (bucket[j*SLOT_W + VAL_W +: KEY_W] == EMPTY_KEY);
    end

    // Lowest-index priority pick for both match and free slot.
    always_comb begin
        free_ix = '0;
        hit_ix  = '0;
        for (int j = SLOTS - 1; j >= 0; j--) begin
            if (empty_vec[j]) free_ix = SLOT_IX_W'(j);
            if (match_vec[j]) hit_ix  = SLOT_IX_W'(j);
        end
        hit       = |match_vec;
        has_free  = |empty_vec;
        hit_value = bucket[hit_ix*SLOT_W +: VAL_W];
    end

    // Bucket image with the pair dropped into the chosen empty slot.
    always_comb begin
        new_bucket = bucket;
        new_bucket[free_ix*SLOT_W +: SLOT_W] = {key, value};
    end

endmodule

// File: rtl/hash_bucket_unit.sv
// Slotted bucket hash unit: one hash table in 256-bit-wide external memory.
// Each request issues a bucket read at once; read data, which must return
// in issue order, is paired with queued metadata and resolved into a
// response and, for a successful insert, a whole-bucket write-back.
// Assumes the requester keeps same-bucket requests from overlapping.
module hash_bucket_unit
    import hbu_pkg::*;
#(
    parameter int          NUM_BUCKETS  = 64,
    parameter int          ADDR_W       = 32,
    parameter int unsigned TABLE_BASE   = 0,
    parameter int unsigned TABLE_STRIDE = 1,
    parameter int          TAG_W        = 8,
    parameter int          MAX_OUTST    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_is_insert,
    input  logic [KEY_W-1:0]    req_key,
    input  logic [VAL_W-1:0]    req_value,
    input  logic [TAG_W-1:0]    req_tag,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rsp_valid,
    output logic                mem_rsp_ready,
    input  logic [BUCKET_W-1:0] mem_rsp_data,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [BUCKET_W-1:0] mem_wr_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic                rsp_is_insert,
    output logic [1:0]          rsp_status,
    output logic [VAL_W-1:0]    rsp_value
);

    localparam int META_W = 1 + KEY_W + VAL_W + TAG_W + ADDR_W;

    logic              fifo_full, fifo_empty, push, take;
    logic [META_W-1:0] meta_in, meta_out;
    logic [ADDR_W-1:0] req_addr;

    logic              h_ins;
    logic [KEY_W-1:0]  h_key;
    logic [VAL_W-1:0]  h_val;
    logic [TAG_W-1:0]  h_tag;
    logic [ADDR_W-1:0] h_addr;

    logic                hit, has_free;
    logic [VAL_W-1:0]    hit_value;
    logic [BUCKET_W-1:0] new_bucket;

    hbu_status_e      res_status;
    logic [VAL_W-1:0] res_value;
    logic             res_write;
    logic             load_ok;

    logic                rsp_valid_q, wr_valid_q;
    logic [TAG_W-1:0]    rsp_tag_q;
    logic                rsp_ins_q;
    hbu_status_e         rsp_status_q;
    logic [VAL_W-1:0]    rsp_value_q;
    logic [ADDR_W-1:0]   wr_addr_q;
    logic [BUCKET_W-1:0] wr_data_q;

    hbu_bucket_locator #(
        .NUM_BUCKETS (NUM_BUCKETS),
        .ADDR_W      (ADDR_W),
        .TABLE_BASE  (TABLE_BASE),
        .TABLE_STRIDE(TABLE_STRIDE)
    ) u_locator (
        .key  (req_key),
        .addr (req_addr)
    );

    // Request side: a read goes out as soon as memory and the queue allow.
    always_comb begin
        req_ready    = mem_rd_ready && !fifo_full;
        mem_rd_valid = req_valid && !fifo_full;
        mem_rd_addr  = req_addr;
        push         = req_valid && req_ready;
        meta_in      = {req_is_insert, req_key, req_value, req_tag, req_addr};
    end

    hbu_meta_fifo #(
        .WIDTH (META_W),
        .DEPTH (MAX_OUTST)
    ) u_meta (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (meta_in),
        .pop   (take),
        .dout  (meta_out),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Unpack the metadata of the oldest request in flight.
    always_comb begin
        {h_ins, h_key, h_val, h_tag, h_addr} = meta_out;
    end

    hbu_slot_logic u_slots (
        .bucket     (mem_rsp_data),
        .key        (h_key),
        .value      (h_val),
        .hit        (hit),
        .hit_value  (hit_value),
        .has_free   (has_free),
        .new_bucket (new_bucket)
    );

    // Resolve the bucket into a status, a value and a write decision.
    always_comb begin
        res_value = '0;
        res_write = 1'b0;
        if (h_key == EMPTY_KEY) begin
            res_status = ST_RSVD;
        end else if (h_ins) begin
            res_status = has_free ? ST_OK : ST_OVF;
            res_write  = has_free;
        end else if (hit) begin
            res_status = ST_OK;
            res_value  = hit_value;
        end else begin
            res_status = ST_MISS;
        end
    end

    // Read data is taken only when both output registers can accept it.
    always_comb begin
        load_ok       = (!rsp_valid_q || rsp_ready) && (!wr_valid_q || mem_wr_ready);
        mem_rsp_ready = load_ok && !fifo_empty;
        take          = mem_rsp_valid && mem_rsp_ready;
    end

    // Output valid flags: set on load, cleared when their port drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            wr_valid_q  <= 1'b0;
        end else begin
            if (take) begin
                rsp_valid_q <= 1'b1;
            end else if (rsp_ready) begin
                rsp_valid_q <= 1'b0;
            end
            if (take) begin
                wr_valid_q <= res_write;
            end else if (mem_wr_ready) begin
                wr_valid_q <= 1'b0;
            end
        end
    end

    // Output payload registers, loaded together with the valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_tag_q    <= '0;
            rsp_ins_q    <= 1'b0;
            rsp_status_q <= ST_OK;
            rsp_value_q  <= '0;
            wr_addr_q    <= '0;
            wr_data_q    <= '0;
        end else if (take) begin
            rsp_tag_q    <= h_tag;
            rsp_ins_q    <= h_ins;
            rsp_status_q <= res_status;
            rsp_value_q  <= res_value;
            wr_addr_q    <= h_addr;
            wr_data_q    <= new_bucket;
        end
    end

    // Drive the response and write-back ports from the registers.
    always_comb begin
        rsp_valid     = rsp_valid_q;
        rsp_tag       = rsp_tag_q;
        rsp_is_insert = rsp_ins_q;
        rsp_status    = rsp_status_q;
        rsp_value     = rsp_value_q;
        mem_wr_valid  = wr_valid_q;
        mem_wr_addr   = wr_addr_q;
        mem_wr_data   = wr_data_q;
    end

endmodule

// File: rtl/hbu_checker.sv
// Port-level properties of the hash unit, bound to every instance.
// Tracks reads in flight with its own counter rather than internal state.
module hbu_checker #(
    parameter int          NUM_BUCKETS  = 64,
    parameter int          ADDR_W       = 32,
    parameter int unsigned TABLE_BASE   = 0,
    parameter int unsigned TABLE_STRIDE = 1,
    parameter int          TAG_W        = 8,
    parameter int          MAX_OUTST    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_ready,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [255:0]      mem_wr_data,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              rsp_is_insert,
    input logic [1:0]        rsp_status,
    input logic [31:0]       rsp_value
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
    localparam logic [ADDR_W-1:0] STR_A  = ADDR_W'(TABLE_STRIDE);
    localparam logic [ADDR_W-1:0] NB_A   = ADDR_W'(NUM_BUCKETS);

    int unsigned outst;

    // Reads issued minus read data consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= 0;
        end else begin
            outst <= outst + ((mem_rd_valid && mem_rd_ready) ? 1 : 0)
                           - ((mem_rsp_valid && mem_rsp_ready) ? 1 : 0);
        end
    end

    p_outst_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= MAX_OUTST);

    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (outst == MAX_OUTST) |-> !req_ready);

    p_rd_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> req_valid);

    p_rd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr >= BASE_A)
                      && ((mem_rd_addr - BASE_A) % STR_A == '0)
                      && ((mem_rd_addr - BASE_A) / STR_A < NB_A));

    p_wr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_addr >= BASE_A)
                      && ((mem_wr_addr - BASE_A) % STR_A == '0));

    p_write_only_ok_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> rsp_valid && rsp_is_insert && (rsp_status == 2'd0));

    p_fail_value_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status != 2'd0 || rsp_is_insert)) |-> (rsp_value == '0));

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_tag)
                                   && $stable(rsp_status) && $stable(rsp_value));

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> mem_wr_valid && $stable(mem_wr_addr)
                                          && $stable(mem_wr_data));

endmodule

bind hash_bucket_unit hbu_checker #(
    .NUM_BUCKETS  (NUM_BUCKETS),
    .ADDR_W       (ADDR_W),
    .TABLE_BASE   (TABLE_BASE),
    .TABLE_STRIDE (TABLE_STRIDE),
    .TAG_W        (TAG_W),
    .MAX_OUTST    (MAX_OUTST)
) u_hbu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_ready  (mem_wr_ready),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_tag       (rsp_tag),
    .rsp_is_insert (rsp_is_insert),
    .rsp_status    (rsp_status),
    .rsp_value     (rsp_value)
);

// File: tb/hash_bucket_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walked one request at a time, then
// directed tests for a stalled write port and a stalled response port.
module hash_bucket_unit_bench;

    localparam int NB     = 8;
    localparam int BASE   = 16;
    localparam int STRIDE = 3;
    localparam int TAG_W  = 8;
    localparam int OUTST  = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_is_insert = 1'b0;
    logic [31:0]  req_key = '0, req_value = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic         req_ready;
    logic         mem_rd_valid, mem_rd_ready = 1'b1;
    logic [31:0]  mem_rd_addr;
    logic         mem_rsp_valid, mem_rsp_ready;
    logic [255:0] mem_rsp_data;
    logic         mem_wr_valid, mem_wr_ready = 1'b1;
    logic [31:0]  mem_wr_addr;
    logic [255:0] mem_wr_data;
    logic         rsp_valid, rsp_ready = 1'b1;
    logic [TAG_W-1:0] rsp_tag;
    logic         rsp_is_insert;
    logic [1:0]   rsp_status;
    logic [31:0]  rsp_value;

    always #2.5 clk = ~clk;

    hash_bucket_unit #(
        .NUM_BUCKETS(NB), .ADDR_W(32), .TABLE_BASE(BASE),
        .TABLE_STRIDE(STRIDE), .TAG_W(TAG_W), .MAX_OUTST(OUTST)
    ) u_hash_bucket_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_insert(req_is_insert), .req_key(req_key),
        .req_value(req_value), .req_tag(req_tag),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
        .rsp_is_insert(rsp_is_insert), .rsp_status(rsp_status),
        .rsp_value(rsp_value)
    );

    // Memory model: 64 words, in-order read data queue, immediate writes.
    logic [255:0] mem [64];
    logic [255:0] rq [64];
    int           rq_wp = 0, rq_rp = 0;
    logic         mem_clear = 1'b0;

    assign mem_rsp_valid = (rq_wp != rq_rp);
    assign mem_rsp_data  = rq[rq_rp % 64];

    always @(posedge clk) begin
        if (mem_clear) begin
            for (int i = 0; i < 64; i++) mem[i] <= '1;
        end else if (mem_wr_valid && mem_wr_ready) begin
            mem[mem_wr_addr[5:0]] <= mem_wr_data;
        end
        if (!rst_n) begin
            rq_wp <= 0;
            rq_rp <= 0;
        end else begin
            if (mem_rd_valid && mem_rd_ready) begin
                rq[rq_wp % 64] <= mem[mem_rd_addr[5:0]];
                rq_wp <= rq_wp + 1;
            end
            if (mem_rsp_valid && mem_rsp_ready) rq_rp <= rq_rp + 1;
        end
    end

    // Port monitor: records responses, writes and read addresses.
    int          rsp_cnt = 0, wr_cnt = 0;
    logic [TAG_W-1:0] r_tag [64];
    logic [1:0]  r_st [64];
    logic [31:0] r_val [64];
    logic        r_ins [64];
    logic [31:0] last_wr_addr = '0, last_rd_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rsp_cnt = 0;
            wr_cnt  = 0;
        end else begin
            if (rsp_valid && rsp_ready) begin
                r_tag[rsp_cnt % 64] = rsp_tag;
                r_st[rsp_cnt % 64]  = rsp_status;
                r_val[rsp_cnt % 64] = rsp_value;
                r_ins[rsp_cnt % 64] = rsp_is_insert;
                rsp_cnt++;
            end
            if (mem_wr_valid && mem_wr_ready) begin
                wr_cnt++;
                last_wr_addr = mem_wr_addr;
            end
            if (mem_rd_valid && mem_rd_ready) last_rd_addr = mem_rd_addr;
        end
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Vector: {is_insert, key, value, expected status, expected value}.
    localparam int NV = 18;
    localparam logic [98:0] VEC [NV] = '{
        {1'b1, 32'd3,   32'hA0, 2'd0, 32'h0},
        {1'b0, 32'd3,   32'h0,  2'd0, 32'hA0},
        {1'b0, 32'd11,  32'h0,  2'd1, 32'h0},
        {1'b1, 32'd11,  32'hB1, 2'd0, 32'h0},
        {1'b1, 32'd19,  32'hC2, 2'd0, 32'h0},
        {1'b1, 32'd27,  32'hD3, 2'd0, 32'h0},
        {1'b1, 32'd35,  32'hE4, 2'd2, 32'h0},
        {1'b0, 32'd35,  32'h0,  2'd1, 32'h0},
        {1'b0, 32'd27,  32'h0,  2'd0, 32'hD3},
        {1'b0, 32'd19,  32'h0,  2'd0, 32'hC2},
        {1'b1, 32'hFFFFFFFF, 32'h1, 2'd3, 32'h0},
        {1'b0, 32'hFFFFFFFF, 32'h0, 2'd3, 32'h0},
        {1'b1, 32'd4,   32'h44, 2'd0, 32'h0},
        {1'b0, 32'd4,   32'h0,  2'd0, 32'h44},
        {1'b0, 32'd12,  32'h0,  2'd1, 32'h0},
        {1'b1, 32'd12,  32'h55, 2'd0, 32'h0},
        {1'b0, 32'd12,  32'h0,  2'd0, 32'h55},
        {1'b1, 32'd13,  32'h66, 2'd0, 32'h0}
    };

    // Issue one request and wait until it has been accepted.
    task automatic send(input logic ins, input logic [31:0] k, input logic [31:0] v,
                        input logic [TAG_W-1:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_is_insert = ins; req_key = k; req_value = v; req_tag = t;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int target);
        for (int g = 0; g < 200 && rsp_cnt < target; g++) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        mem_clear = 1'b1;
        repeat (3) @(negedge clk);
        mem_clear = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] k);
        return 32'(BASE) + (k % NB) * 32'(STRIDE);
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset state.
        rst_n = 1'b0;
        mem_clear = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk("R1 mem_wr_valid in reset", 64'(mem_wr_valid), 64'd0);
        chk("R1 mem_rd_valid idle", 64'(mem_rd_valid), 64'd0);
        mem_clear = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

        // Vector walk, one request in flight at a time.
        for (int i = 0; i < NV; i++) begin
            logic        ins;
            logic [31:0] k, v, ev;
            logic [1:0]  es;
            int          rb, wb;
            {ins, k, v, es, ev} = VEC[i];
            rb = rsp_cnt;
            wb = wr_cnt;
            send(ins, k, v, TAG_W'(i));
            wait_rsp(rb + 1);
            @(negedge clk);
            chk($sformatf("R4/R5/R6/R7 status vec%0d", i), 64'(r_st[rb % 64]), 64'(es));
            chk($sformatf("R4/R5 value vec%0d", i), 64'(r_val[rb % 64]), 64'(ev));
            chk($sformatf("R8 tag vec%0d", i), 64'(r_tag[rb % 64]), 64'(i));
            chk($sformatf("R8 opcode vec%0d", i), 64'(r_ins[rb % 64]), 64'(ins));
            chk($sformatf("R3/R6 write count vec%0d", i), 64'(wr_cnt - wb),
                (ins && es == 2'd0) ? 64'd1 : 64'd0);
            chk($sformatf("R2 read address vec%0d", i), 64'(last_rd_addr), 64'(exp_addr(k)));
            if (ins && es == 2'd0)
                chk($sformatf("R2 write address vec%0d", i), 64'(last_wr_addr), 64'(exp_addr(k)));
        end

        // R3: slot layout inside the stored buckets.
        chk("R3 bucket3 slot0", mem[25][63:0],    {32'd3,  32'hA0});
        chk("R3 bucket3 slot1", mem[25][127:64],  {32'd11, 32'hB1});
        chk("R3 bucket3 slot3", mem[25][255:192], {32'd27, 32'hD3});
        chk("R3 bucket4 slot1", mem[28][127:64],  {32'd12, 32'h55});
        chk("R3 bucket4 slot2 empty", mem[28][191:128], 64'hFFFFFFFF_FFFFFFFF);

        // R10: write port stalled holds the write-back.
        begin
            int wb;
            mem_wr_ready = 1'b0;
            wb = wr_cnt;
            send(1'b1, 32'd5, 32'h77, 8'd90);
            wait_rsp(NV + 1);
            repeat (4) @(negedge clk);
            chk("R10 write held valid", 64'(mem_wr_valid), 64'd1);
            chk("R10 write held address", 64'(mem_wr_addr), 64'(exp_addr(32'd5)));
            chk("R10 write not taken", 64'(wr_cnt - wb), 64'd0);
            mem_wr_ready = 1'b1;
            repeat (2) @(negedge clk);
            chk("R10 write released", 64'(wr_cnt - wb), 64'd1);
            chk("R3 second free slot", mem[31][127:64], {32'd5, 32'h77});
        end

        // R9/R8/R10: stalled response port, back-to-back probes.
        do_reset();
        rsp_ready = 1'b0;
        begin
            int acc;
            acc = 0;
            for (int c = 0; c < 80; c++) begin
                logic rdy;
                @(negedge clk);
                req_valid = 1'b1; req_is_insert = 1'b0;
                req_key = 32'(acc); req_tag = TAG_W'(acc);
                #1;
                rdy = req_ready;
                @(posedge clk);
                if (rdy) acc++;
            end
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk("R9 accepted under stall", 64'(acc), 64'(OUTST + 1));
            chk("R9 req_ready low when full", 64'(req_ready), 64'd0);
            chk("R10 response held valid", 64'(rsp_valid), 64'd1);
            chk("R10 response held tag", 64'(rsp_tag), 64'd0);
            rsp_ready = 1'b1;
            wait_rsp(OUTST + 1);
            @(negedge clk);
            chk("R9 all responses returned", 64'(rsp_cnt), 64'(OUTST + 1));
            for (int i = 0; i < OUTST + 1; i++) begin
                chk($sformatf("R8 order tag %0d", i), 64'(r_tag[i]), 64'(i));
                chk($sformatf("R5 empty table miss %0d", i), 64'(r_st[i]), 64'd1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule